// File: doc/BRIEF.md
# Peripheral Window Address Decoder

This block sits between the system bus and a population of peripheral slaves. It decodes one 64 MB address window into per-slave module enables. Each access is presented as an address with a valid strobe. The decoder works out which region of the window the address falls in, and then which 16 KB slot within that region. It then raises exactly one enable, registered so that the enable lines up with the access phase one clock later.

The window has four parts. The lowest 0.5 MB holds 32 on-platform slots of 16 KB each. The next 0.5 MB holds 32 off-platform slots of 16 KB each. Any hit on one of the off-platform slots also raises a single aggregate enable. The remaining 63 MB is split evenly by address between two coarse global expansion enables. A valid access whose address lies outside the window raises a miss flag and no enable.

The window base is a parameter and must be aligned to 64 MB. The slot count, slot size and window size come from a shared package.

Top module: `pbdec_top`

## Requirements
- R1: Every output shows the decode of the access presented on the previous rising clock edge, one cycle of latency, and no output changes between edges.
- R2: A valid access at window offset 0x0000000 to 0x007FFFF asserts bit offset[18:14] of `on_en_o` and no other output.
- R3: A valid access at window offset 0x0080000 to 0x00FFFFF asserts bit offset[18:14] of `off_en_o`.
- R4: `off_any_o` is high exactly when one bit of `off_en_o` is high, and that happens only for an access in the R3 range.
- R5: A valid access at window offset 0x0100000 to 0x207FFFF asserts `glb_en_o[0]` alone.
- R6: A valid access at window offset 0x2080000 to 0x3FFFFFF asserts `glb_en_o[1]` alone.
- R7: A valid access whose address bits [31:26] differ from those of the window base asserts `miss_o` and no enable.
- R8: While `valid_i` is low, the next cycle shows every enable and `miss_o` low, whatever the address.
- R9: At most one bit among `on_en_o`, `off_en_o` and `glb_en_o` is high in any cycle.
- R10: While reset is asserted, and in the first cycle after it is released, every output is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | An access is presented this cycle |
| addr_i | input | 32 | System-bus byte address |
| on_en_o | output | 32 | One-hot enables of the on-platform slots |
| off_en_o | output | 32 | One-hot enables of the off-platform slots |
| glb_en_o | output | 2 | Global expansion enables, lower half then upper half |
| off_any_o | output | 1 | Aggregate enable for any off-platform slot hit |
| miss_o | output | 1 | Valid access outside the window |

## Verification
Every result of this block is due exactly one rising edge after its access is presented. The bench drives an access on a falling edge and compares all outputs on the next falling edge, once the single register stage has captured the decode. A separate R1 check samples the outputs on the same falling edge where a new access is driven, and expects them to still hold the previous decode. R8 is checked one cycle after a cycle with the strobe low, and the assertions use one-cycle implications that match the same register stage.

// File: rtl/pbdec_pkg.sv
package pbdec_pkg;
    localparam int unsigned ADDR_W      = 32;
    localparam int unsigned WIN_LOG2    = 26;
    localparam int unsigned SLOT_LOG2   = 14;
    localparam int unsigned SLOTS       = 32;
    localparam int unsigned IDX_W       = $clog2(SLOTS);
    localparam int unsigned REGION_LOG2 = SLOT_LOG2 + IDX_W;
    localparam int unsigned GLB_N       = 2;

    typedef enum logic [2:0] {
        RG_IDLE,
        RG_ONPLAT,
        RG_OFFPLAT,
        RG_GLB_LO,
        RG_GLB_HI,
        RG_MISS
    } region_e;

    typedef struct packed {
        logic [SLOTS-1:0] on_en;
        logic [SLOTS-1:0] off_en;
        logic [GLB_N-1:0] glb_en;
        logic             off_any;
        logic             miss;
    } dec_out_t;
endpackage

// File: rtl/pbdec_region.sv
module pbdec_region
    import pbdec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hC000_0000
) (
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    output region_e           region_o,
    output logic [IDX_W-1:0]  idx_o
);
    localparam longint unsigned WIN_SIZE_L  = 64'd1 << WIN_LOG2;
    localparam longint unsigned OFF_LO_L    = 64'd1 << REGION_LOG2;
    localparam longint unsigned GLB_LO_L    = 64'd2 << REGION_LOG2;
    localparam longint unsigned GLB_SPLIT_L = GLB_LO_L + (WIN_SIZE_L - GLB_LO_L) / 2;

    localparam logic [WIN_LOG2-1:0] OFF_LO    = WIN_LOG2'(OFF_LO_L);
    localparam logic [WIN_LOG2-1:0] GLB_LO    = WIN_LOG2'(GLB_LO_L);
    localparam logic [WIN_LOG2-1:0] GLB_SPLIT = WIN_LOG2'(GLB_SPLIT_L);

    logic                in_win;
    logic [WIN_LOG2-1:0] offset;

    assign in_win = (addr_i[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);
    assign offset = addr_i[WIN_LOG2-1:0];
    assign idx_o  = addr_i[SLOT_LOG2 +: IDX_W];

    always_comb begin
        if (!valid_i) begin
            region_o = RG_IDLE;
        end else if (!in_win) begin
            region_o = RG_MISS;
        end else if (offset < OFF_LO) begin
            region_o = RG_ONPLAT;
        end else if (offset < GLB_LO) begin
            region_o = RG_OFFPLAT;
        end else if (offset < GLB_SPLIT) begin
            region_o = RG_GLB_LO;
        end else begin
            region_o = RG_GLB_HI;
        end
    end
endmodule

// File: rtl/pbdec_onehot.sv
module pbdec_onehot #(
    parameter int unsigned N     = 32,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic             en_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic [N-1:0]     oh_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        assign oh_o[g] = en_i && (idx_i == IDX_W'(g));
    end
endmodule

// File: rtl/pbdec_top.sv
module pbdec_top
    import pbdec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hC000_0000
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              valid_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [SLOTS-1:0]  on_en_o,
    output logic [SLOTS-1:0]  off_en_o,
    output logic [GLB_N-1:0]  glb_en_o,
    output logic              off_any_o,
    output logic              miss_o
);
    region_e          region;
    logic [IDX_W-1:0] idx;
    logic [SLOTS-1:0] on_oh;
    logic [SLOTS-1:0] off_oh;
    dec_out_t         dec_d;
    dec_out_t         dec_q;

    pbdec_region #(.WIN_BASE(WIN_BASE)) u_region (
        .valid_i  (valid_i),
        .addr_i   (addr_i),
        .region_o (region),
        .idx_o    (idx)
    );

    pbdec_onehot #(.N(SLOTS), .IDX_W(IDX_W)) u_on_oh (
        .en_i  (region == RG_ONPLAT),
        .idx_i (idx),
        .oh_o  (on_oh)
    );

    pbdec_onehot #(.N(SLOTS), .IDX_W(IDX_W)) u_off_oh (
        .en_i  (region == RG_OFFPLAT),
        .idx_i (idx),
        .oh_o  (off_oh)
    );

    always_comb begin
        dec_d           = '0;
        dec_d.on_en     = on_oh;
        dec_d.off_en    = off_oh;
        dec_d.glb_en[0] = (region == RG_GLB_LO);
        dec_d.glb_en[1] = (region == RG_GLB_HI);
        dec_d.off_any   = (region == RG_OFFPLAT);
        dec_d.miss      = (region == RG_MISS);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dec_q <= '0;
        end else begin
            dec_q <= dec_d;
        end
    end

    assign on_en_o   = dec_q.on_en;
    assign off_en_o  = dec_q.off_en;
    assign glb_en_o  = dec_q.glb_en;
    assign off_any_o = dec_q.off_any;
    assign miss_o    = dec_q.miss;
endmodule

// File: rtl/pbdec_chk.sv
module pbdec_chk
    import pbdec_pkg::*;
#(
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'hC000_0000
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              valid_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [SLOTS-1:0]  on_en_o,
    input logic [SLOTS-1:0]  off_en_o,
    input logic [GLB_N-1:0]  glb_en_o,
    input logic              off_any_o,
    input logic              miss_o
);
    logic [2*SLOTS+GLB_N-1:0] all_en;
    logic                     in_win;

    assign all_en = {on_en_o, off_en_o, glb_en_o};
    assign in_win = (addr_i[ADDR_W-1:WIN_LOG2] == WIN_BASE[ADDR_W-1:WIN_LOG2]);

    a_r9_at_most_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(all_en));

    a_r7_miss_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
        miss_o |-> (all_en == '0));

    a_r4_aggregate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        off_any_o == (off_en_o != '0));

    a_r8_idle_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |=> ((all_en == '0) && !miss_o && !off_any_o));

    a_r1_hit_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && in_win) |=> (($countones(all_en) == 1) && !miss_o));

    a_r7_miss_next_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && !in_win) |=> miss_o);
endmodule

bind pbdec_top pbdec_chk #(.WIN_BASE(WIN_BASE)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (valid_i),
    .addr_i    (addr_i),
    .on_en_o   (on_en_o),
    .off_en_o  (off_en_o),
    .glb_en_o  (glb_en_o),
    .off_any_o (off_any_o),
    .miss_o    (miss_o)
);

// File: tb/sim_pbdec_top.sv
`timescale 1ns/1ps
module sim_pbdec_top;
    import pbdec_pkg::*;

    localparam logic [31:0] BASE = 32'hC000_0000;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic [31:0] on_en_o, off_en_o;
    logic [1:0]  glb_en_o;
    logic        off_any_o, miss_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk_i = ~clk_i;

    pbdec_top #(.WIN_BASE(BASE)) u0 (
        .clk_i, .rst_ni, .valid_i, .addr_i,
        .on_en_o, .off_en_o, .glb_en_o, .off_any_o, .miss_o
    );

    function automatic dec_out_t expect_of(input logic v, input logic [31:0] a);
        dec_out_t e = '0;
        logic [25:0] off = a[25:0];
        if (!v) return e;
        if (a[31:26] != BASE[31:26]) begin
            e.miss = 1'b1;
        end else if (off < 26'h008_0000) begin
            e.on_en[off[18:14]] = 1'b1;
        end else if (off < 26'h010_0000) begin
            e.off_en[off[18:14]] = 1'b1;
            e.off_any = 1'b1;
        end else if (off < 26'h208_0000) begin
            e.glb_en[0] = 1'b1;
        end else begin
            e.glb_en[1] = 1'b1;
        end
        return e;
    endfunction

    function automatic string tag_of(input logic v, input logic [31:0] a);
        logic [25:0] off = a[25:0];
        if (!v) return "R8";
        if (a[31:26] != BASE[31:26]) return "R7";
        if (off < 26'h008_0000) return "R2";
        if (off < 26'h010_0000) return "R3/R4";
        if (off < 26'h208_0000) return "R5";
        return "R6";
    endfunction

    function automatic dec_out_t got_now();
        dec_out_t g;
        g.on_en = on_en_o; g.off_en = off_en_o; g.glb_en = glb_en_o;
        g.off_any = off_any_o; g.miss = miss_o;
        return g;
    endfunction

    task automatic compare(input string tag, input dec_out_t e);
        dec_out_t g = got_now();
        checks++;
        if (g !== e) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, g, e);
        end
    endtask

    // Drive on a falling edge, compare one rising edge later on the next falling edge.
    task automatic access(input logic v, input logic [31:0] a);
        @(negedge clk_i);
        valid_i = v;
        addr_i  = a;
        @(negedge clk_i);
        compare(tag_of(v, a), expect_of(v, a));
    endtask

    initial begin
        dec_out_t prev;
        void'($urandom(32'd20240611));
        // R10: outputs low during reset, even with a valid hit presented
        valid_i = 1'b1;
        addr_i  = BASE;
        repeat (3) @(negedge clk_i);
        compare("R10 in reset", '0);
        valid_i = 1'b0;
        @(negedge clk_i);
        rst_ni = 1'b1;
        compare("R10 after release", '0);

        // Directed boundaries
        access(1'b1, BASE + 32'h000_0000);
        access(1'b1, BASE + 32'h007_FFFF);
        access(1'b1, BASE + 32'h000_4000);
        access(1'b1, BASE + 32'h008_0000);
        access(1'b1, BASE + 32'h00F_FFFF);
        access(1'b1, BASE + 32'h00A_C123);
        access(1'b1, BASE + 32'h010_0000);
        access(1'b1, BASE + 32'h207_FFFF);
        access(1'b1, BASE + 32'h208_0000);
        access(1'b1, BASE + 32'h3FF_FFFF);
        access(1'b1, BASE - 32'h1);
        access(1'b1, BASE + 32'h400_0000);
        access(1'b0, BASE + 32'h008_0000);
        access(1'b0, 32'h0000_0000);

        // R1: on the edge where a new access is driven, outputs still hold the previous one
        access(1'b1, BASE + 32'h009_0000);
        prev = expect_of(1'b1, BASE + 32'h009_0000);
        @(negedge clk_i);
        valid_i = 1'b1;
        addr_i  = BASE + 32'h300_0000;
        #1;
        compare("R1 hold before edge", prev);
        @(negedge clk_i);
        compare("R1 after edge", expect_of(1'b1, BASE + 32'h300_0000));

        // Random mix
        for (int i = 0; i < 800; i++) begin
            logic [31:0] a;
            logic v;
            v = ($urandom_range(9) != 0);
            if ($urandom_range(7) == 0) a = $urandom();
            else if ($urandom_range(2) == 0) a = BASE + ($urandom() & 32'h000F_FFFF);
            else a = BASE + ($urandom() & 32'h03FF_FFFF);
            access(v, a);
        end

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule